// File: doc/BRIEF.md
# Replayable FIFO Buffer with Occupancy Flags

This block is a single-clock first-in/first-out buffer. It is 9 bits wide by default and its depth is set by a parameter. Words go into an internal array at the write pointer and come out in arrival order at the read pointer. Three registered flags, empty, full and half-full, report occupancy. A write strobe that would overflow the buffer is dropped, and so is a read strobe that would underflow it.

A rewind request sends only the read pointer back to the first location. The write pointer stays where it is, and the flags are rebuilt from the new gap between the two pointers. A producer can therefore fill the buffer once after reset and have the consumer replay that block as many times as needed. The replay is exact as long as fewer than DEPTH words have been written since the last reset.

Read data is registered. A qualifier marks it valid for one cycle after each accepted read. In every other cycle the qualifier is low and the data bus is forced to zero.

Top module: `replay_fifo`

## Requirements
- R1: While reset (`rstN` low, asynchronous) is applied, and after it is released, empty is 1, full is 0, half-full is 0, `rdValid` is 0 and `rdData` is 0. Both pointers start at location 0.
- R2: Accepted reads return the written words in the order they were written. Each word appears on `rdData`, with `rdValid` high, in the cycle after the read strobe.
- R3: A write strobe that arrives while full is high and no read is accepted in the same cycle is dropped. Full stays high, and the stored words are neither changed nor added to.
- R4: A read strobe that arrives while empty is high is dropped. `rdValid` stays 0, the read pointer stays where it is, and empty stays high unless a write is accepted in the same cycle.
- R5: Empty goes high in the cycle after the read that takes the last stored word.
- R6: Starting from reset with no reads, full is still low after DEPTH-1 writes and goes high after exactly DEPTH writes.
- R7: Half-full is high exactly when occupancy is greater than DEPTH/2. It rises on the write that takes occupancy above DEPTH/2 and falls on the read that brings occupancy back to DEPTH/2 or less.
- R8: A rewind sets the read pointer to location 0 and leaves the write pointer unchanged. Occupancy becomes the write-pointer position, all three flags follow from that value, and the reads that follow replay the buffer from location 0.
- R9: Read and write strobes that arrive in the same cycle as a rewind are dropped. In the following cycle `rdValid` is 0.
- R10: A read and a write accepted in the same cycle leave occupancy unchanged. While full, a simultaneous read and write are both accepted.
- R11: `rdValid` is 0 and `rdData` is 0 in every cycle that does not follow an accepted read.
- R12: All flags are registered and show the occupancy that results from a cycle's strobes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStb | input | 1 | Write request for this cycle |
| wrData | input | DATA_W | Word to store |
| rdStb | input | 1 | Read request for this cycle |
| rewind | input | 1 | Move the read pointer back to location 0 |
| rdData | output | DATA_W | Word read out; 0 when not valid |
| rdValid | output | 1 | High in the cycle after an accepted read |
| emptyFlag | output | 1 | Occupancy is zero |
| fullFlag | output | 1 | Occupancy equals DEPTH |
| halfFlag | output | 1 | Occupancy greater than DEPTH/2 |

## Verification
Every result is due one clock edge after the stimulus that causes it. The flags, `rdValid` and `rdData` are all taken from registers loaded at the edge where the strobes are sampled. The bench drives strobes on the falling edge and then updates its own occupancy and pointer model. It checks the flags on the next falling edge, half a cycle after the loading edge. For each accepted read the driver pushes the expected word onto a queue. A monitor then pops one entry on each falling edge where `rdValid` is high, and on every other falling edge it checks that the data bus is zero.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;

  // Per-cycle actions that the control side grants to the datapath
  typedef struct packed {
    logic wrEn;    // store wrData at the write pointer, then advance it
    logic rdEn;    // load the word at the read pointer, then advance it
    logic rewind;  // return the read pointer to location zero
  } fifoStrobes_t;

endpackage

// File: rtl/replay_fifo_ctrl.sv
module replay_fifo_ctrl
  import replay_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrStb,
  input  logic                     rdStb,
  input  logic                     rewind,
  input  logic [$clog2(DEPTH)-1:0] wrPos,
  output fifoStrobes_t             strobes,
  output logic                     emptyFlag,
  output logic                     fullFlag,
  output logic                     halfFlag
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic [CNT_W-1:0] occ;
  logic [CNT_W-1:0] occNext;
  logic             rdOk;
  logic             wrOk;

  // A read needs data; a write needs space, or a read that frees a slot
  // in the same cycle. A rewind blocks both.
  always_comb begin
    rdOk = rdStb && !rewind && (occ != '0);
    wrOk = wrStb && !rewind && ((occ != FULL_CNT) || rdOk);
    strobes.wrEn   = wrOk;
    strobes.rdEn   = rdOk;
    strobes.rewind = rewind;
  end

  always_comb begin
    if (rewind) begin
      // The read pointer goes to zero, so the distance is the write position
      occNext = CNT_W'(wrPos);
    end else begin
      occNext = occ;
      if (wrOk && !rdOk) occNext = occ + 1'b1;
      if (rdOk && !wrOk) occNext = occ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ       <= '0;
      emptyFlag <= 1'b1;
      fullFlag  <= 1'b0;
      halfFlag  <= 1'b0;
    end else begin
      occ       <= occNext;
      emptyFlag <= (occNext == '0);
      fullFlag  <= (occNext == FULL_CNT);
      halfFlag  <= (occNext > HALF_CNT);
    end
  end

  // PTR_W is used only to size wrPos
  initial begin
    if (PTR_W < 1) $error("DEPTH must be at least 2");
  end

endmodule

// File: rtl/replay_fifo_data.sv
module replay_fifo_data
  import replay_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fifoStrobes_t             strobes,
  input  logic [DATA_W-1:0]        wrData,
  output logic [$clog2(DEPTH)-1:0] wrPos,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdValid
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  assign wrPos = wrPtr;

  always_ff @(posedge clk) begin
    if (strobes.wrEn) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (strobes.wrEn) begin
      wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else if (strobes.rewind) begin
      rdPtr   <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else if (strobes.rdEn) begin
      rdPtr   <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      rdData  <= store[rdPtr];
      rdValid <= 1'b1;
    end else begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end
  end

endmodule

// File: rtl/replay_fifo.sv
module replay_fifo
  import replay_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStb,
  input  logic              rewind,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              emptyFlag,
  output logic              fullFlag,
  output logic              halfFlag
);

  localparam int PTR_W = $clog2(DEPTH);

  fifoStrobes_t     strobes;
  logic [PTR_W-1:0] wrPos;

  replay_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrStb     (wrStb),
    .rdStb     (rdStb),
    .rewind    (rewind),
    .wrPos     (wrPos),
    .strobes   (strobes),
    .emptyFlag (emptyFlag),
    .fullFlag  (fullFlag),
    .halfFlag  (halfFlag)
  );

  replay_fifo_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .wrPos   (wrPos),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

endmodule

// File: rtl/replay_fifo_chk.sv
module replay_fifo_chk #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStb,
  input logic              rdStb,
  input logic              rewind,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              emptyFlag,
  input logic              fullFlag,
  input logic              halfFlag
);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (fullFlag && wrStb && !rdStb && !rewind) |=> fullFlag);

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (emptyFlag && rdStb && !rewind) |=> !rdValid);

  a_r4_empty_holds: assert property (@(posedge clk) disable iff (!rstN)
    (emptyFlag && !wrStb && !rewind) |=> emptyFlag);

  a_r9_rewind_no_read: assert property (@(posedge clk) disable iff (!rstN)
    rewind |=> !rdValid);

  a_r10_full_both: assert property (@(posedge clk) disable iff (!rstN)
    (fullFlag && wrStb && rdStb && !rewind) |=> (fullFlag && rdValid));

  a_r11_quiet_bus: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

  a_r7_full_implies_half: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag |-> (halfFlag && !emptyFlag));

  a_r7_empty_not_half: assert property (@(posedge clk) disable iff (!rstN)
    emptyFlag |-> !halfFlag);

endmodule

bind replay_fifo replay_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrStb     (wrStb),
  .rdStb     (rdStb),
  .rewind    (rewind),
  .rdData    (rdData),
  .rdValid   (rdValid),
  .emptyFlag (emptyFlag),
  .fullFlag  (fullFlag),
  .halfFlag  (halfFlag)
);

// File: tb/replay_fifo_bench.sv
`timescale 1ns/1ps
module replay_fifo_bench;

  localparam int DATA_W = 9;
  localparam int DEPTH  = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrStb = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic              rdStb = 1'b0;
  logic              rewind = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic              rdValid;
  logic              emptyFlag;
  logic              fullFlag;
  logic              halfFlag;

  always #2.5 clk = ~clk;

  replay_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_replay_fifo (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData), .rdStb(rdStb),
    .rewind(rewind), .rdData(rdData), .rdValid(rdValid),
    .emptyFlag(emptyFlag), .fullFlag(fullFlag), .halfFlag(halfFlag)
  );

  int checks = 0;
  int fails  = 0;

  // Bench model of occupancy and pointers, built from the requirements
  logic [DATA_W-1:0] modelMem [DEPTH];
  int wrIdx = 0;
  int rdIdx = 0;
  int occ   = 0;
  logic [DATA_W-1:0] expQ [$];
  logic monOn = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkFlags(input string tag);
    check(emptyFlag == (occ == 0), {tag, " R5 empty"}, emptyFlag, occ == 0);
    check(fullFlag == (occ == DEPTH), {tag, " R6 full"}, fullFlag, occ == DEPTH);
    check(halfFlag == (occ > DEPTH / 2), {tag, " R7 half"}, halfFlag, occ > DEPTH / 2);
  endtask

  // One cycle of stimulus, starting and ending at a falling edge
  task automatic step(input bit w, input logic [DATA_W-1:0] d, input bit r, input bit rw);
    bit rdOk;
    bit wrOk;
    wrStb = w; wrData = d; rdStb = r; rewind = rw;
    if (rw) begin
      rdIdx = 0;
      occ = wrIdx;
    end else begin
      rdOk = r && (occ > 0);
      wrOk = w && ((occ < DEPTH) || rdOk);
      if (rdOk) begin
        expQ.push_back(modelMem[rdIdx]);
        rdIdx = (rdIdx + 1) % DEPTH;
        occ--;
      end
      if (wrOk) begin
        modelMem[wrIdx] = d;
        wrIdx = (wrIdx + 1) % DEPTH;
        occ++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    wrStb = 1'b0; rdStb = 1'b0; rewind = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    wrIdx = 0; rdIdx = 0; occ = 0;
    expQ.delete();
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Scoreboard monitor: one pop per valid word; a quiet bus otherwise (R2, R11)
  always @(negedge clk) begin
    if (monOn && rstN) begin
      if (rdValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R4 unexpected rdValid", rdData, 0);
        end else begin
          logic [DATA_W-1:0] e;
          e = expQ.pop_front();
          check(rdData == e, "R2 read order", rdData, e);
        end
      end else begin
        check(rdData == '0, "R11 idle bus", rdData, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1: state during and after reset
    @(negedge clk);
    check(emptyFlag && !fullFlag && !halfFlag && !rdValid, "R1 during reset",
          {emptyFlag, fullFlag, halfFlag, rdValid}, 4'b1000);
    doReset();
    check(emptyFlag && !fullFlag && !halfFlag && !rdValid && rdData == 0,
          "R1 after reset", {emptyFlag, fullFlag, halfFlag, rdValid}, 4'b1000);
    monOn = 1'b1;

    // R4: read while empty is dropped
    step(0, 0, 1, 0);
    check(!rdValid, "R4 read on empty", rdValid, 0);
    checkFlags("R4");

    // R2, R5: short burst in and out
    for (int i = 0; i < 5; i++) step(1, 9'(8'h30 + i), 0, 0);
    checkFlags("R12 after writes");
    for (int i = 0; i < 5; i++) begin
      step(0, 0, 1, 0);
      check(rdValid, "R2 valid after read", rdValid, 1);
    end
    checkFlags("R5 drained");
    check(emptyFlag, "R5 empty after last read", emptyFlag, 1);

    // R6, R7: fill from reset
    doReset();
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 9'(9'h100 + i), 0, 0);
      if (i == DEPTH / 2 - 1) check(!halfFlag, "R7 half at DEPTH/2", halfFlag, 0);
      if (i == DEPTH / 2) check(halfFlag, "R7 half above DEPTH/2", halfFlag, 1);
      if (i == DEPTH - 2) check(!fullFlag, "R6 not full at DEPTH-1", fullFlag, 0);
    end
    check(fullFlag, "R6 full at DEPTH", fullFlag, 1);

    // R3: write while full is dropped
    step(1, 9'h1AA, 0, 0);
    check(fullFlag, "R3 still full", fullFlag, 1);
    checkFlags("R3");

    // R10: read and write together while full
    step(1, 9'h055, 1, 0);
    check(fullFlag, "R10 full kept", fullFlag, 1);
    check(rdValid, "R10 read accepted", rdValid, 1);

    // R7: drain, half falls at DEPTH/2
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 0, 1, 0);
      if (occ == DEPTH / 2) check(!halfFlag, "R7 half cleared", halfFlag, 0);
    end
    checkFlags("R5 drained full");

    // R8: rewind replays from location zero
    doReset();
    for (int i = 0; i < 6; i++) step(1, 9'(9'h0C0 + i), 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0);
    step(0, 0, 0, 1);
    checkFlags("R8 after rewind");
    check(!emptyFlag, "R8 occupancy restored", emptyFlag, 0);

    // R9: strobes with a rewind are dropped
    step(1, 9'h1FF, 1, 1);
    check(!rdValid, "R9 no read with rewind", rdValid, 0);
    checkFlags("R9 flags unchanged");
    for (int i = 0; i < 6; i++) step(0, 0, 1, 0);
    checkFlags("R8 replay drained");

    // R10: simultaneous read and write mid-level
    step(1, 9'h011, 0, 0);
    step(1, 9'h012, 0, 0);
    step(1, 9'h013, 1, 0);
    checkFlags("R10 level kept");

    // Mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom_range(0, 1)), 9'($urandom), 1'($urandom_range(0, 1)), 1'b0);
      checkFlags("R12 mixed");
    end
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 1, 0);
    check(expQ.size() == 0, "R2 all reads returned", expQ.size(), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule